// File: doc/BRIEF.md
# Digitizer Channel Frame Packer

This block turns the stored samples of one digitizer channel into a framed burst of 32-bit words for a readout receiver. Each word pairs one 10-bit sample from the upper half of the digitizer with one from the lower half. It also carries the channel number and the trigger event count, a frame-begin marker, a frame-end marker and an even-parity bit. A frame is always 128 words long. While the frame is on the link, a valid line stays high, and a per-word strobe marks each cycle that holds a word.

A one-cycle start pulse launches a frame. At that edge the block latches the channel number, the event count and a leading-gap setting of 0 to 3. The block reads the channel's sample buffer one word ahead of the output, using a one-cycle read latency. After valid rises, it keeps the strobe low for the number of gap cycles selected. This gives a receiver that needs setup time a chance to get ready before word 0 arrives. A gap of 0 gives the plain timing. The busy output covers the whole frame, and any start that arrives while busy is high is ignored.

Top module: `frame_packer`

## Requirements
- R1: After reset and whenever idle, busy, tx_valid, tx_strobe and buf_rd_en are low and tx_word is all zeros.
- R2: In the first cycle after an accepted start, busy is high, tx_valid is low and the buffer is read at address 0 (buf_rd_en high, buf_rd_addr 0).
- R3: tx_valid rises in the second cycle after start. For G cycles (G = gap_sel latched at start, 0..3), tx_strobe stays low and tx_word is zero.
- R4: Exactly 128 words follow the gap on consecutive cycles with tx_strobe high. Word i carries the upper sample stored at buffer address i in bits [19:10] and the lower sample in bits [9:0].
- R5: Bit [31] (frame begin) is 1 only in word 0. Bit [30] (frame end) is 1 only in word 127.
- R6: Bits [28:25] carry the channel and bits [24:21] the event count, both latched at start; later changes on those inputs do not affect the frame. Bit [20] is always 0.
- R7: Bit [29] makes the count of ones in bits [29:0] even.
- R8: A start while busy is ignored. In the cycle after word 127, busy and tx_valid are low, and a new start is accepted from then on.
- R9: While word i (i < 127) is on the output, buf_rd_en is high and buf_rd_addr is i+1. During word 127 and during the gap cycles, buf_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a frame (one-cycle pulse) |
| chan_id | input | 4 | Channel number, latched at start |
| evt_cnt | input | 4 | Trigger event count, latched at start |
| gap_sel | input | 2 | Leading strobe-free cycles after valid rises |
| buf_rd_en | output | 1 | Sample buffer read enable |
| buf_rd_addr | output | 7 | Sample buffer word address |
| buf_upper | input | 10 | Upper-half sample, one cycle after read |
| buf_lower | input | 10 | Lower-half sample, one cycle after read |
| busy | output | 1 | Frame in progress |
| tx_valid | output | 1 | Frame valid line toward receiver |
| tx_strobe | output | 1 | Current cycle holds a word |
| tx_word | output | 32 | Framed output word |

## Verification
The bench runs frames with each gap setting from 0 to 3. This separates a correct gap length from an off-by-one in valid or strobe placement. The sample contents change from frame to frame, and the upper and lower samples follow different patterns, so a swapped half or an address that lags by one word shows up at once. One frame changes the channel and event inputs and pulses start in the middle of the frame. Another pulses start in the last word cycle and then starts a new frame back to back. Together these tell latched header fields from live ones, and an ignored restart from one that is accepted.

// File: rtl/frame_packer.sv
module frame_packer #(
  parameter int SAMPLE_W = 10,
  parameter int TAG_W    = 4,
  parameter int GAP_W    = 2,
  parameter int WORDS    = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [TAG_W-1:0]         chan_id,
  input  logic [TAG_W-1:0]         evt_cnt,
  input  logic [GAP_W-1:0]         gap_sel,
  output logic                     buf_rd_en,
  output logic [$clog2(WORDS)-1:0] buf_rd_addr,
  input  logic [SAMPLE_W-1:0]      buf_upper,
  input  logic [SAMPLE_W-1:0]      buf_lower,
  output logic                     busy,
  output logic                     tx_valid,
  output logic                     tx_strobe,
  output logic [3+2*TAG_W+2*SAMPLE_W:0] tx_word
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int BODY_W = 2*TAG_W + 1 + 2*SAMPLE_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS-1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_GAP, S_SEND} st_t;

  st_t              st;
  logic [GAP_W-1:0] gap_left;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] chan_q, evt_q;
  logic [BODY_W-1:0] body;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      gap_left <= '0;
      idx      <= '0;
      chan_q   <= '0;
      evt_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_PRE;
          gap_left <= gap_sel;
          idx      <= '0;
          chan_q   <= chan_id;
          evt_q    <= evt_cnt;
        end
        S_PRE:  st <= (gap_left != '0) ? S_GAP : S_SEND;
        S_GAP: begin
          gap_left <= gap_left - 1'b1;
          if (gap_left == GAP_W'(1)) st <= S_SEND;
        end
        S_SEND: begin
          if (idx == LAST) st <= S_IDLE;
          else             idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign tx_valid    = (st == S_GAP) || (st == S_SEND);
  assign tx_strobe   = (st == S_SEND);
  assign buf_rd_en   = (st == S_PRE) || (tx_strobe && idx != LAST);
  assign buf_rd_addr = tx_strobe ? idx + 1'b1 : '0;

  assign body    = {chan_q, evt_q, 1'b0, buf_upper, buf_lower};
  assign tx_word = tx_strobe ? {idx == '0, idx == LAST, ^body, body} : '0;
endmodule

module frame_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        tx_valid,
  input logic        tx_strobe,
  input logic        buf_rd_en,
  input logic [31:0] tx_word
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (tx_word == '0 && !buf_rd_en && !tx_valid)); // R1
  AST_STROBE_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n) tx_strobe |-> tx_valid); // R3
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> busy); // R8
  AST_MARKERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) (tx_strobe && tx_word[31]) |-> !tx_word[30]); // R5
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n) tx_strobe |-> (^tx_word[29:0] == 1'b0)); // R7
  AST_HEADER_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (tx_strobe && $past(tx_strobe)) |-> (tx_word[28:20] == $past(tx_word[28:20]))); // R6
  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (tx_strobe && tx_word[30]) |=> (!busy && !tx_valid)); // R8
  AST_BEGIN_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_strobe) |-> tx_word[31]); // R4
endmodule

bind frame_packer frame_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_valid(tx_valid),
  .tx_strobe(tx_strobe), .buf_rd_en(buf_rd_en), .tx_word(tx_word)
);

// File: tb/frame_packer_tb.sv
module frame_packer_tb;
  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] chan_id = 0, evt_cnt = 0;
  logic [1:0] gap_sel = 0;
  logic buf_rd_en;
  logic [6:0] buf_rd_addr;
  logic [9:0] buf_upper = 0, buf_lower = 0;
  logic busy, tx_valid, tx_strobe;
  logic [31:0] tx_word;
  int total = 0, bad = 0, seed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_packer u_dut (.*);

  function automatic logic [9:0] up_of(int s, int i); return 10'((s*7 + i*13) & 1023); endfunction
  function automatic logic [9:0] lo_of(int s, int i); return 10'((s*29 + i*5 + 3) & 1023); endfunction

  always_ff @(posedge clk) if (buf_rd_en) begin
    buf_upper <= up_of(seed, int'(buf_rd_addr));
    buf_lower <= lo_of(seed, int'(buf_rd_addr));
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(busy == 0, req, 32'(busy), 0);
    chk(tx_valid == 0 && tx_strobe == 0, req, {tx_valid, tx_strobe}, 0);
    chk(buf_rd_en == 0, req, 32'(buf_rd_en), 0);
    chk(tx_word == 0, req, tx_word, 0);
  endtask

  function automatic logic [31:0] exp_word(int s, int i, logic [3:0] ch, logic [3:0] ev);
    logic [31:0] w;
    w = {1'b0, 1'b0, 1'b0, ch, ev, 1'b0, up_of(s, i), lo_of(s, i)};
    w[31] = (i == 0);
    w[30] = (i == 127);
    w[29] = $countones(w[28:0]) % 2 == 1;
    return w;
  endfunction

  // at a negedge on entry; returns at negedge after idle check
  task automatic run_frame(input int g, input logic [3:0] ch, input logic [3:0] ev,
                           input int s, input bit disturb, input bit late_start);
    seed = s; chan_id = ch; evt_cnt = ev; gap_sel = 2'(g); start = 1;
    for (int k = 1; k <= g + 130; k++) begin
      @(negedge clk);
      start = 0;
      if (k == 1) begin
        chk(busy && !tx_valid && !tx_strobe, "R2", {busy, tx_valid, tx_strobe}, 3'b100);
        chk(buf_rd_en && buf_rd_addr == 0, "R2", {buf_rd_en, buf_rd_addr}, 8'h80);
      end else if (k <= g + 1) begin
        chk(busy && tx_valid, "R3", {busy, tx_valid}, 2'b11);
        chk(!tx_strobe && tx_word == 0, "R3", tx_word, 0);
        chk(!buf_rd_en, "R9", 32'(buf_rd_en), 0);
      end else if (k <= g + 129) begin
        int w = k - g - 2;
        logic [31:0] e = exp_word(s, w, ch, ev);
        chk(busy && tx_valid && tx_strobe, "R4", {busy, tx_valid, tx_strobe}, 3'b111);
        chk(tx_word[19:0] == e[19:0], "R4", tx_word, e);
        chk(tx_word[31:30] == e[31:30], "R5", tx_word, e);
        chk(tx_word[28:20] == e[28:20], "R6", tx_word, e);
        chk(tx_word[29] == e[29], "R7", tx_word, e);
        if (w < 127) chk(buf_rd_en && buf_rd_addr == 7'(w + 1), "R9", {buf_rd_en, buf_rd_addr}, {1'b1, 7'(w + 1)});
        else         chk(!buf_rd_en, "R9", 32'(buf_rd_en), 0);
        if (disturb && w == 50) begin
          start = 1; chan_id = ~ch; evt_cnt = ~ev; gap_sel = ~gap_sel;
        end
        if (late_start && w == 127) start = 1;
      end else begin
        chk_idle("R8");
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");
    run_frame(0, 4'h3, 4'h9, 1, 0, 0);
    run_frame(1, 4'hA, 4'h5, 2, 0, 0);
    run_frame(2, 4'hF, 4'h0, 3, 1, 0);   // mid-frame start and header change: R6, R8
    run_frame(3, 4'h6, 4'hC, 4, 0, 1);   // start in last word ignored: R8
    run_frame(0, 4'h1, 4'hE, 5, 0, 0);   // back to back
    repeat (2) begin @(negedge clk); chk_idle("R1"); end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule